// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from eight peripheral lines and tells the processor when one of them needs attention. It keeps three 8-bit registers: the levels that are waiting for service, the levels being serviced, and a mask. When a level that is not masked is waiting, and it outranks everything already in service, the block raises its interrupt output. The processor then answers with two acknowledge pulses. The first pulse moves the winning level from waiting to in-service. The second pulse returns an 8-bit vector that names the service routine.

Software programs the controller through a small register port. The port has a select, read and write strobes, one address bit, and separate write and read data buses. An initialization sequence of two or three writes sets the vector base and the end-of-interrupt policy. After that, writes set the mask, issue end-of-interrupt commands, and choose which register a status read returns. If a request vanishes before it is acknowledged, the controller returns the level-7 vector, so the processor always gets a vector.

Top module: `prio_intc`

## Requirements
- R1: Each request line is edge triggered. Its pending bit sets at the first clock edge that sees the line high after it was low at the previous edge. The bit clears at any edge where the line is low, and also when the level is acknowledged.
- R2: A mask bit set to 1 stops only its own level from raising the interrupt or winning an acknowledge. Pending bits are still recorded while their level is masked, and other levels behave as if the mask bit were clear. The mask is written with address bit 1 once initialization is complete.
- R3: A write with address bit 0 and data bit 4 set begins initialization. It clears the mask and every pending bit, and it selects the pending register for status reads. A line that is already high must go low and then high again before it counts. Data bit 0 of that write says whether a third initialization write follows.
- R4: In the initialization sequence, the next write with address bit 1 sets the vector base from data bits 7:3. The optional third write (address bit 1) turns on automatic end-of-interrupt through its data bit 1. A sequence without the third write leaves automatic end-of-interrupt off.
- R5: Priority is fixed, with level 0 highest and level 7 lowest. The interrupt output is high exactly when the highest-priority unmasked pending level outranks every in-service level.
- R6: The first acknowledge pulse sets the in-service bit of the qualifying level from R5 and clears its pending bit. It produces no vector.
- R7: The second acknowledge pulse produces the vector {base[4:0], level[2:0]} on the vector output. The vector-valid flag is high for exactly the one cycle after that pulse.
- R8: With automatic end-of-interrupt on, the second acknowledge pulse clears the acknowledged in-service bit.
- R9: A write with address bit 0 and data bits 4:3 = 00 is a command. Data bits 7:5 = 001 clear the highest-priority in-service bit. Data bits 7:5 = 011 clear the in-service bit of the level in data bits 2:0.
- R10: A write with address bit 0 and data bits 4:3 = 01 is a read-select command. When data bit 1 is 1, data bit 0 selects the in-service register (1) or the pending register (0) for reads at address 0. A read at address 1 returns the mask. The read bus is 0 when no read is active.
- R11: If no level qualifies at the first acknowledge pulse, the second pulse returns level 7 with the current base, and no in-service bit is set.
- R12: If an end-of-interrupt command and a first acknowledge pulse arrive in the same cycle, both take effect. The command acts on the in-service bits as they were before the acknowledge added its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register port select |
| wr_en | input | 1 | Write strobe, qualified by sel |
| rd_en | input | 1 | Read strobe, qualified by sel |
| addr0 | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when no read is active |
| irq_in | input | 8 | Request lines, bit n is level n |
| int_out | output | 1 | Interrupt to the processor |
| inta | input | 1 | Acknowledge pulse, one cycle per pulse |
| vec_out | output | 8 | Vector from the last second acknowledge pulse |
| vec_valid | output | 1 | Vector valid for one cycle |

## Verification
Two functions can change the in-service register in the same cycle: a first acknowledge pulse and a non-specific end-of-interrupt write. The bench sets this up with level 3 already in service and level 1 newly pending. It then drives the command write and the acknowledge pulse on the same clock edge. The result is judged by reading back the in-service register, which must hold only level 1. The following second acknowledge pulse must still return the level-1 vector.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVLS = 8;
  localparam int LW   = $clog2(LVLS);
  localparam int DW   = 8;
  localparam int VBW  = DW - LW;

  typedef logic [LVLS-1:0] lvl_vec_t;

  typedef struct packed {
    logic          hit;
    logic [LW-1:0] idx;
  } pick_t;

  typedef enum logic [1:0] {CFG_RUN, CFG_W2, CFG_W4} cfg_st_t;

  // lowest set index wins (level 0 highest priority)
  function automatic pick_t first_set(lvl_vec_t v);
    pick_t p;
    p = '0;
    for (int i = LVLS - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.hit = 1'b1;
        p.idx = LW'(i);
      end
    end
    return p;
  endfunction

  function automatic lvl_vec_t onehot(logic [LW-1:0] i);
    return lvl_vec_t'(1) << i;
  endfunction
endpackage

// File: rtl/intc_req_latch.sv
module intc_req_latch
  import intc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lvl_vec_t irq_in,
  input  logic     rearm,
  input  lvl_vec_t ack_clr,
  output lvl_vec_t irr
);
  lvl_vec_t prev_q;
  lvl_vec_t rise;

  always_comb rise = irq_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      irr    <= '0;
    end else if (rearm) begin
      prev_q <= '1;
      irr    <= '0;
    end else begin
      prev_q <= irq_in;
      irr    <= irq_in & (irr | rise) & ~ack_clr;
    end
  end
endmodule

// File: rtl/intc_resolver.sv
module intc_resolver
  import intc_pkg::*;
(
  input  lvl_vec_t irr,
  input  lvl_vec_t mask,
  input  lvl_vec_t isr,
  output pick_t    cand,
  output pick_t    isr_top,
  output logic     int_req
);
  pick_t pend_top;

  always_comb begin
    pend_top = first_set(irr & ~mask);
    isr_top  = first_set(isr);
    int_req  = pend_top.hit && (!isr_top.hit || (pend_top.idx < isr_top.idx));
    cand     = int_req ? pend_top : '0;
  end
endmodule

// File: rtl/intc_cfg.sv
module intc_cfg
  import intc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_stb,
  input  logic           addr0,
  input  logic [DW-1:0]  wdata,
  output lvl_vec_t       mask,
  output logic [VBW-1:0] vbase,
  output logic           aeoi,
  output logic           rd_isr,
  output logic           icw1_evt,
  output logic           eoi_ns,
  output logic           eoi_sp,
  output logic [LW-1:0]  eoi_lvl
);
  cfg_st_t st_q;
  logic    ic4_q;
  logic    is_cmd, sel_cmd;

  always_comb begin
    icw1_evt = wr_stb && !addr0 && wdata[4];
    is_cmd   = wr_stb && !addr0 && !wdata[4];
    sel_cmd  = is_cmd && wdata[3];
    eoi_ns   = is_cmd && !wdata[3] && (wdata[7:5] == 3'b001);
    eoi_sp   = is_cmd && !wdata[3] && (wdata[7:5] == 3'b011);
    eoi_lvl  = wdata[LW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CFG_RUN;
      ic4_q  <= 1'b0;
      mask   <= '0;
      vbase  <= '0;
      aeoi   <= 1'b0;
      rd_isr <= 1'b0;
    end else if (icw1_evt) begin
      st_q   <= CFG_W2;
      ic4_q  <= wdata[0];
      mask   <= '0;
      aeoi   <= 1'b0;
      rd_isr <= 1'b0;
    end else if (wr_stb && addr0) begin
      case (st_q)
        CFG_W2: begin
          vbase <= wdata[DW-1:LW];
          st_q  <= ic4_q ? CFG_W4 : CFG_RUN;
        end
        CFG_W4: begin
          aeoi <= wdata[1];
          st_q <= CFG_RUN;
        end
        default: mask <= wdata[LVLS-1:0];
      endcase
    end else if (sel_cmd && wdata[1]) begin
      rd_isr <= wdata[0];
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int DATA_W = intc_pkg::DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr0,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [LVLS-1:0]   irq_in,
  output logic              int_out,
  input  logic              inta,
  output logic [DATA_W-1:0] vec_out,
  output logic              vec_valid
);
  localparam logic [LW-1:0] DEFAULT_LVL = LW'(LVLS - 1);

  lvl_vec_t       irr, isr, mask;
  lvl_vec_t       isr_set, eoi_clr;
  logic [VBW-1:0] vbase;
  logic           aeoi, rd_isr, icw1_evt, eoi_ns, eoi_sp;
  logic [LW-1:0]  eoi_lvl;
  pick_t          cand, isr_top;
  logic           int_req;

  logic           phase_q;
  logic [LW-1:0]  cap_idx;
  logic           cap_real;
  logic           wr_stb, rd_stb, ack_first, ack_second;

  always_comb begin
    wr_stb     = sel && wr_en;
    rd_stb     = sel && rd_en;
    ack_first  = inta && !phase_q;
    ack_second = inta && phase_q;
  end

  intc_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr0(addr0), .wdata(wdata),
    .mask(mask), .vbase(vbase), .aeoi(aeoi), .rd_isr(rd_isr),
    .icw1_evt(icw1_evt), .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_lvl(eoi_lvl)
  );

  intc_req_latch u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rearm(icw1_evt),
    .ack_clr(isr_set), .irr(irr)
  );

  intc_resolver u_res (
    .irr(irr), .mask(mask), .isr(isr),
    .cand(cand), .isr_top(isr_top), .int_req(int_req)
  );

  always_comb begin
    isr_set = (ack_first && cand.hit) ? onehot(cand.idx) : '0;
    eoi_clr = '0;
    if (eoi_ns && isr_top.hit) eoi_clr |= onehot(isr_top.idx);
    if (eoi_sp)                eoi_clr |= onehot(eoi_lvl);
    if (ack_second && aeoi && cap_real) eoi_clr |= onehot(cap_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr       <= '0;
      phase_q   <= 1'b0;
      cap_idx   <= '0;
      cap_real  <= 1'b0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      isr       <= (isr & ~eoi_clr) | isr_set;
      vec_valid <= ack_second;
      if (ack_first) begin
        phase_q  <= 1'b1;
        cap_real <= cand.hit;
        cap_idx  <= cand.hit ? cand.idx : DEFAULT_LVL;
      end
      if (ack_second) begin
        phase_q <= 1'b0;
        vec_out <= {vbase, cap_idx};
      end
    end
  end

  always_comb begin
    int_out = int_req;
    if (!rd_stb)    rdata = '0;
    else if (addr0) rdata = mask;
    else if (rd_isr) rdata = isr;
    else            rdata = irr;
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] irq_in,
  input logic [7:0] irr,
  input logic [7:0] mask,
  input logic [7:0] isr,
  input logic       int_out,
  input logic       ack_first,
  input logic       ack_second,
  input logic       cand_hit,
  input logic [2:0] cand_idx,
  input logic       icw1_evt,
  input logic       cap_real,
  input logic       vec_valid,
  input logic [7:0] vec_out
);
  AST_PEND_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (irr & ~$past(irq_in)) == 8'h00); // R1
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_evt |=> (mask == 8'h00 && irr == 8'h00)); // R3
  AST_INT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask) != 8'h00)); // R5
  AST_ACK1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_first |=> !vec_valid); // R6
  AST_ACK1_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_first && cand_hit) |=> isr[$past(cand_idx)]); // R6
  AST_ACK2_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_second |=> vec_valid); // R7
  AST_DEFAULT_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_second && !cap_real) |=> (vec_out[2:0] == 3'd7)); // R11
endmodule

bind prio_intc intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irr(irr), .mask(mask),
  .isr(isr), .int_out(int_out), .ack_first(ack_first), .ack_second(ack_second),
  .cand_hit(cand.hit), .cand_idx(cand.idx), .icw1_evt(icw1_evt),
  .cap_real(cap_real), .vec_valid(vec_valid), .vec_out(vec_out)
);

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, addr0 = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] irq_in = '0;
  logic       int_out;
  logic       inta = 1'b0;
  logic [7:0] vec_out;
  logic       vec_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  prio_intc uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .addr0(addr0), .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
    .int_out(int_out), .inta(inta), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // all tasks start just after a falling edge and end just after one
  task automatic wr(logic a, logic [7:0] d);
    sel = 1; wr_en = 1; addr0 = a; wdata = d;
    @(negedge clk);
    sel = 0; wr_en = 0; addr0 = 0; wdata = '0;
  endtask

  task automatic rd_chk(string req, logic a, logic [7:0] exp);
    sel = 1; rd_en = 1; addr0 = a;
    #1 chk(req, rdata, exp);
    @(negedge clk);
    sel = 0; rd_en = 0; addr0 = 0;
  endtask

  task automatic int_chk(string req, logic exp);
    @(negedge clk);
    #1 chk(req, {7'd0, int_out}, {7'd0, exp});
  endtask

  task automatic ack_pair(string req, logic [7:0] exp_vec);
    inta = 1;
    @(negedge clk);
    inta = 0;
    #1 chk({req, " first pulse no vector"}, {7'd0, vec_valid}, 8'd0);
    inta = 1;
    @(negedge clk);
    inta = 0;
    #1 chk({req, " valid"}, {7'd0, vec_valid}, 8'd1);
    chk({req, " vector"}, vec_out, exp_vec);
    @(negedge clk);
    #1 chk({req, " valid one cycle"}, {7'd0, vec_valid}, 8'd0);
  endtask

  task automatic t_reset;
    #1 chk("R5 reset int", {7'd0, int_out}, 8'd0);
    chk("R7 reset valid", {7'd0, vec_valid}, 8'd0);
    chk("R10 idle read bus", rdata, 8'd0);
    rd_chk("R10 reset pending", 1'b0, 8'h00);
  endtask

  task automatic t_init_basic;
    wr(0, 8'h13); wr(1, 8'h40); wr(1, 8'h00);
    rd_chk("R3 mask after init", 1'b1, 8'h00);
    irq_in[3] = 1;
    int_chk("R1 R5 rise raises int", 1'b1);
    rd_chk("R1 pending bit 3", 1'b0, 8'h08);
    inta = 1; @(negedge clk); inta = 0;
    #1 chk("R6 no vector on first pulse", {7'd0, vec_valid}, 8'd0);
    rd_chk("R6 pending cleared", 1'b0, 8'h00);
    wr(0, 8'h0B);
    rd_chk("R6 in-service bit 3", 1'b0, 8'h08);
    inta = 1; @(negedge clk); inta = 0;
    #1 chk("R7 vector", vec_out, 8'h43);
    chk("R7 valid", {7'd0, vec_valid}, 8'd1);
    rd_chk("R8 no auto clear", 1'b0, 8'h08);
    wr(0, 8'h20);
    rd_chk("R9 nonspecific clears", 1'b0, 8'h00);
    wr(0, 8'h0A);
    irq_in[3] = 0;
    @(negedge clk);
  endtask

  task automatic t_priority;
    irq_in[5] = 1; irq_in[2] = 1;
    int_chk("R5 int with two pending", 1'b1);
    ack_pair("R5 R7 higher level first", 8'h42);
    #1 chk("R5 lower waits behind in-service", {7'd0, int_out}, 8'd0);
    wr(0, 8'h20);
    #1 chk("R5 int after EOI", {7'd0, int_out}, 8'd1);
    ack_pair("R7 second level", 8'h45);
    wr(0, 8'h20);
    irq_in = '0;
    @(negedge clk);
  endtask

  task automatic t_mask;
    wr(1, 8'h04);
    irq_in[2] = 1;
    int_chk("R2 masked no int", 1'b0);
    rd_chk("R2 masked still pending", 1'b0, 8'h04);
    irq_in[6] = 1;
    int_chk("R2 other level unaffected", 1'b1);
    ack_pair("R2 vector skips masked", 8'h46);
    wr(0, 8'h20);
    rd_chk("R10 mask readback", 1'b1, 8'h04);
    wr(1, 8'h00);
    #1 chk("R2 unmask raises int", {7'd0, int_out}, 8'd1);
    ack_pair("R2 unmasked vector", 8'h42);
    wr(0, 8'h20);
    irq_in = '0;
    @(negedge clk);
  endtask

  task automatic t_reinit;
    irq_in[4] = 1;
    @(negedge clk);
    ack_pair("R7 level 4", 8'h44);
    irq_in[1] = 1;
    @(negedge clk);
    wr(1, 8'hFF);
    wr(0, 8'h0B);
    rd_chk("R10 isr selected", 1'b0, 8'h10);
    wr(0, 8'h13); wr(1, 8'h80); wr(1, 8'h02);
    #1 chk("R3 held line gives no int", {7'd0, int_out}, 8'd0);
    rd_chk("R3 read select back to pending", 1'b0, 8'h00);
    rd_chk("R3 mask cleared", 1'b1, 8'h00);
    wr(0, 8'h64);
    wr(0, 8'h0B);
    rd_chk("R9 specific EOI level 4", 1'b0, 8'h00);
    irq_in[1] = 0;
    @(negedge clk);
    irq_in[1] = 1;
    int_chk("R1 fresh edge after init", 1'b1);
    ack_pair("R4 new base vector", 8'h81);
    rd_chk("R8 auto EOI cleared", 1'b0, 8'h00);
    irq_in = '0;
    @(negedge clk);
  endtask

  task automatic t_default7;
    wr(0, 8'h0A);
    irq_in[0] = 1;
    int_chk("R11 short request raises int", 1'b1);
    irq_in[0] = 0;
    int_chk("R1 R11 request gone", 1'b0);
    ack_pair("R11 default level", 8'h87);
    wr(0, 8'h0B);
    rd_chk("R11 no in-service bit", 1'b0, 8'h00);
  endtask

  task automatic t_concurrent;
    wr(0, 8'h12); wr(1, 8'h40);
    irq_in[3] = 1;
    @(negedge clk);
    ack_pair("R4 no fourth word", 8'h43);
    irq_in[1] = 1;
    int_chk("R5 higher preempts", 1'b1);
    sel = 1; wr_en = 1; addr0 = 0; wdata = 8'h20; inta = 1;
    @(negedge clk);
    sel = 0; wr_en = 0; wdata = '0; inta = 0;
    wr(0, 8'h0B);
    rd_chk("R12 EOI and ack same cycle", 1'b0, 8'h02);
    inta = 1; @(negedge clk); inta = 0;
    #1 chk("R12 vector after merge", vec_out, 8'h41);
    wr(0, 8'h20);
    rd_chk("R12 final clear", 1'b0, 8'h00);
    irq_in = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_init_basic();
    t_priority();
    t_mask();
    t_reinit();
    t_default7();
    t_concurrent();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule